// File: doc/BRIEF.md
# SDRAM Command Sequencer

This block issues the initialisation and power-management commands for two SDRAM devices that share one command bus. Software writes a single command word. The word carries a 3-bit command code, one select bit per device, a repeat count for auto-refresh and a payload for the device's mode register. The block then drives the command pins for one cycle and holds NOP for the programmed wait interval. A busy output stays high until the command and its wait are complete. While busy is high, further command writes are ignored. Software brings a device up one step at a time: enable the clock, precharge all banks, run eight auto-refreshes (repeat count 7), load the mode register, then enter normal mode.

Once a device has entered normal mode and the global enable is set, a refresh timer issues one auto-refresh to every device that is in normal mode each time its period expires. Self-refresh and power-down drop the device's clock enable. A later normal command brings the device back.

Top module: `sdseq_top`

## Requirements
- R1: After reset, busy is 0, both clock enables are 0, both chip selects are high, RAS_n/CAS_n/WE_n are 1,1,1 and the address bus is 0.
- R2: Command code 2 (precharge all) drives RAS_n,CAS_n,WE_n = 0,1,0 with address bit 10 high and all other address bits low, for one cycle. Only the chip selects of the selected devices go low (word bit 4 selects device 0, bit 3 selects device 1). Busy stays high for tRP+2 cycles, where tRP is timing bits 23:20.
- R3: Command code 3 with repeat field r (word bits 8:5) issues r+1 auto-refresh commands (0,0,1). Each is followed by tRC+1 NOP cycles (tRC is timing bits 15:12), so busy lasts (r+1)*(tRC+2) cycles.
- R4: Command code 4 (load mode) drives 0,0,0 with word bits 21:9 on the address bus, then waits tMRD+1 cycles (tMRD is timing bits 3:0).
- R5: A command write while busy is high has no effect on the pins, busy or clock enables.
- R6: Code 1 raises the clock enable of each selected device. Code 6 (power-down) lowers it and issues only NOPs. Code 0 (normal) raises it and marks the device as in normal mode. Each of these keeps busy high for one cycle.
- R7: Code 5 (self-refresh) issues an auto-refresh with the selected clock enables low in that same cycle. A later code 0 to a device that is in self-refresh waits tXSR+1 cycles (tXSR is timing bits 7:4), so busy lasts tXSR+2 cycles.
- R8: With the global enable high and at least one device in normal mode, one auto-refresh goes to those devices every period+1 cycles. With the enable low, no timed refresh is issued.
- R9: When a command write and a due timed refresh meet on the same idle cycle, the write is taken first. The refresh is issued on the first idle cycle after it and is not lost.
- R10: Code 7 changes no pin and no clock enable, and holds busy for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_en | input | 1 | Global enable for timed refresh |
| tim_cfg | input | 28 | Seven 4-bit timing fields |
| rfsh_period | input | 13 | Refresh timer reload value |
| cmd_we | input | 1 | Command word write strobe |
| cmd_word | input | 22 | Code, selects, repeat count, mode payload |
| busy | output | 1 | Command or wait in progress |
| sd_cke | output | 2 | Clock enable per device |
| sd_cs_n | output | 2 | Chip select per device, active low |
| sd_ras_n | output | 1 | Row strobe |
| sd_cas_n | output | 1 | Column strobe |
| sd_we_n | output | 1 | Write enable |
| sd_ba | output | 2 | Bank address, held 0 |
| sd_addr | output | 13 | Address bus |

## Verification
The hardest case to reach is R9. A software write has to land on exactly the idle cycle in which the timed refresh first becomes due. The ports show nothing of the timer's state. The bench follows its own behavioural copy of the timer count, waits until that count reports expiry at the next edge, and strobes a write on the edge right after. It then checks that the write's NOP appears first and the deferred refresh follows two cycles later. Every other cycle is compared against the same behavioural model, which holds the expected pin sequence in a queue.

// File: rtl/sdseq_pkg.sv
package sdseq_pkg;
  localparam int TF_W   = 4;
  localparam int NDEV   = 2;
  localparam int WAIT_W = TF_W + 1;

  typedef enum logic [2:0] {
    C_NORMAL = 3'd0,
    C_CKE_ON = 3'd1,
    C_PALL   = 3'd2,
    C_AREF   = 3'd3,
    C_LMR    = 3'd4,
    C_SREF   = 3'd5,
    C_PDOWN  = 3'd6,
    C_RSVD   = 3'd7
  } sdcmd_e;

  typedef struct packed {
    logic [TF_W-1:0] trcd;
    logic [TF_W-1:0] trp;
    logic [TF_W-1:0] twr;
    logic [TF_W-1:0] trc;
    logic [TF_W-1:0] tras;
    logic [TF_W-1:0] txsr;
    logic [TF_W-1:0] tmrd;
  } sdtim_t;
endpackage

// File: rtl/sdseq_rfsh_timer.sv
module sdseq_rfsh_timer #(
  parameter int RCNT_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [RCNT_W-1:0] period,
  input  logic              take,
  output logic              pend
);
  logic [RCNT_W-1:0] cnt_q, cnt_d;
  logic              pend_q, pend_d;

  always_comb begin
    cnt_d  = cnt_q;
    pend_d = pend_q;
    if (!run) begin
      cnt_d  = period;
      pend_d = 1'b0;
    end else if (cnt_q == '0) begin
      cnt_d  = period;
      pend_d = 1'b1;
    end else begin
      cnt_d  = cnt_q - 1'b1;
      pend_d = pend_q & ~take;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  assign pend = pend_q;

  AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !pend_q); // R8
  AST_PEND_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !take && run) |=> pend_q); // R9
endmodule

// File: rtl/sdseq_engine.sv
module sdseq_engine
  import sdseq_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int REP_W  = 4,
  parameter int PAY_LSB = 5 + REP_W,
  parameter int CMD_W  = PAY_LSB + ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sdtim_t            tim,
  input  logic              cmd_we,
  input  logic [CMD_W-1:0]  cmd_word,
  input  logic              rf_pend,
  output logic              rf_take,
  output logic [NDEV-1:0]   act,
  output logic              busy,
  output logic [NDEV-1:0]   sd_cke,
  output logic [NDEV-1:0]   sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [ADDR_W-1:0] sd_addr
);
  logic              busy_q, busy_d;
  logic [WAIT_W-1:0] wait_q, wait_d;
  logic [REP_W-1:0]  rep_q, rep_d;
  logic [NDEV-1:0]   sel_q, sel_d, cke_q, cke_d, sr_q, sr_d, act_q, act_d;
  logic [NDEV-1:0]   cs_n_q, cs_n_d;
  logic              ras_q, ras_d, cas_q, cas_d, we_q, we_d;
  logic [ADDR_W-1:0] addr_q, addr_d;

  sdcmd_e            code;
  logic [NDEV-1:0]   sel_in;
  logic              accept;
  logic              unused_tim;

  assign code    = sdcmd_e'(cmd_word[2:0]);
  assign sel_in  = {cmd_word[3], cmd_word[4]};
  assign accept  = cmd_we & ~busy_q;
  assign rf_take = ~busy_q & ~cmd_we & rf_pend;
  assign unused_tim = ^{tim.tras, tim.twr, tim.trcd};

  always_comb begin
    busy_d = busy_q;
    wait_d = wait_q;
    rep_d  = rep_q;
    sel_d  = sel_q;
    cke_d  = cke_q;
    sr_d   = sr_q;
    act_d  = act_q;
    cs_n_d = '1;
    ras_d  = 1'b1;
    cas_d  = 1'b1;
    we_d   = 1'b1;
    addr_d = '0;
    if (busy_q) begin
      if (wait_q != '0) begin
        wait_d = wait_q - 1'b1;
      end else if (rep_q != '0) begin
        rep_d  = rep_q - 1'b1;
        cs_n_d = ~sel_q;
        ras_d  = 1'b0;
        cas_d  = 1'b0;
        wait_d = {1'b0, tim.trc} + WAIT_W'(1);
      end else begin
        busy_d = 1'b0;
      end
    end else if (accept) begin
      busy_d = 1'b1;
      sel_d  = sel_in;
      rep_d  = '0;
      wait_d = '0;
      unique case (code)
        C_NORMAL: begin
          cke_d = cke_q | sel_in;
          act_d = act_q | sel_in;
          sr_d  = sr_q & ~sel_in;
          if ((sel_in & sr_q) != '0) wait_d = {1'b0, tim.txsr} + WAIT_W'(1);
        end
        C_CKE_ON: cke_d = cke_q | sel_in;
        C_PALL: begin
          cs_n_d     = ~sel_in;
          ras_d      = 1'b0;
          we_d       = 1'b0;
          addr_d[10] = 1'b1;
          wait_d     = {1'b0, tim.trp} + WAIT_W'(1);
        end
        C_AREF: begin
          cs_n_d = ~sel_in;
          ras_d  = 1'b0;
          cas_d  = 1'b0;
          rep_d  = cmd_word[5 +: REP_W];
          wait_d = {1'b0, tim.trc} + WAIT_W'(1);
        end
        C_LMR: begin
          cs_n_d = ~sel_in;
          ras_d  = 1'b0;
          cas_d  = 1'b0;
          we_d   = 1'b0;
          addr_d = cmd_word[PAY_LSB +: ADDR_W];
          wait_d = {1'b0, tim.tmrd} + WAIT_W'(1);
        end
        C_SREF: begin
          cs_n_d = ~sel_in;
          ras_d  = 1'b0;
          cas_d  = 1'b0;
          cke_d  = cke_q & ~sel_in;
          sr_d   = sr_q | sel_in;
          act_d  = act_q & ~sel_in;
        end
        C_PDOWN: begin
          cke_d = cke_q & ~sel_in;
          act_d = act_q & ~sel_in;
        end
        default: ;
      endcase
    end else if (rf_take) begin
      busy_d = 1'b1;
      sel_d  = act_q;
      rep_d  = '0;
      cs_n_d = ~act_q;
      ras_d  = 1'b0;
      cas_d  = 1'b0;
      wait_d = {1'b0, tim.trc} + WAIT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      wait_q <= '0;
      rep_q  <= '0;
      sel_q  <= '0;
      cke_q  <= '0;
      sr_q   <= '0;
      act_q  <= '0;
      cs_n_q <= '1;
      ras_q  <= 1'b1;
      cas_q  <= 1'b1;
      we_q   <= 1'b1;
      addr_q <= '0;
    end else begin
      busy_q <= busy_d;
      wait_q <= wait_d;
      rep_q  <= rep_d;
      sel_q  <= sel_d;
      cke_q  <= cke_d;
      sr_q   <= sr_d;
      act_q  <= act_d;
      cs_n_q <= cs_n_d;
      ras_q  <= ras_d;
      cas_q  <= cas_d;
      we_q   <= we_d;
      addr_q <= addr_d;
    end
  end

  assign act      = act_q;
  assign busy     = busy_q;
  assign sd_cke   = cke_q;
  assign sd_cs_n  = cs_n_q;
  assign sd_ras_n = ras_q;
  assign sd_cas_n = cas_q;
  assign sd_we_n  = we_q;
  assign sd_addr  = addr_q;

  AST_NOP_IN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && wait_q != '0) |=> (&cs_n_q)); // R2
  AST_REP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_q != '0) |=> $stable(rep_q)); // R3
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cmd_we) |=> $stable(sel_q)); // R5
  AST_SREF_CKE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_q & cke_q) == '0); // R7
endmodule

// File: rtl/sdseq_top.sv
module sdseq_top
  import sdseq_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int REP_W  = 4,
  parameter int RCNT_W = 13,
  parameter int CMD_W  = 5 + REP_W + ADDR_W,
  parameter int TIM_W  = 7 * TF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_en,
  input  logic [TIM_W-1:0]  tim_cfg,
  input  logic [RCNT_W-1:0] rfsh_period,
  input  logic              cmd_we,
  input  logic [CMD_W-1:0]  cmd_word,
  output logic              busy,
  output logic [NDEV-1:0]   sd_cke,
  output logic [NDEV-1:0]   sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [1:0]        sd_ba,
  output logic [ADDR_W-1:0] sd_addr
);
  logic [1:0]      rs_q;
  logic            rst_int_n;
  logic            pend, take;
  logic [NDEV-1:0] act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  sdseq_rfsh_timer #(.RCNT_W(RCNT_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .run    (ctl_en & (|act)),
    .period (rfsh_period),
    .take   (take),
    .pend   (pend)
  );

  sdseq_engine #(.ADDR_W(ADDR_W), .REP_W(REP_W)) u_engine (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .tim      (sdtim_t'(tim_cfg)),
    .cmd_we   (cmd_we),
    .cmd_word (cmd_word),
    .rf_pend  (pend),
    .rf_take  (take),
    .act      (act),
    .busy     (busy),
    .sd_cke   (sd_cke),
    .sd_cs_n  (sd_cs_n),
    .sd_ras_n (sd_ras_n),
    .sd_cas_n (sd_cas_n),
    .sd_we_n  (sd_we_n),
    .sd_addr  (sd_addr)
  );

  assign sd_ba = '0;
endmodule

// File: tb/sdseq_top_bench.sv
module sdseq_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_en = 1'b0;
  logic [27:0] tim_cfg;
  logic [12:0] rfsh_period = 13'd40;
  logic        cmd_we = 1'b0;
  logic [21:0] cmd_word = '0;
  logic        busy;
  logic [1:0]  sd_cke, sd_cs_n, sd_ba;
  logic        sd_ras_n, sd_cas_n, sd_we_n;
  logic [12:0] sd_addr;

  localparam int TMRD = 1, TXSR = 3, TRC = 4, TRP = 2;
  // trcd=2 trp=2 twr=2 trc=4 tras=5 txsr=3 tmrd=1
  assign tim_cfg = {4'd2, 4'd2, 4'd2, 4'd4, 4'd5, 4'd3, 4'd1};

  always #10 clk = ~clk;

  sdseq_top u_sdseq_top (
    .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en), .tim_cfg(tim_cfg),
    .rfsh_period(rfsh_period), .cmd_we(cmd_we), .cmd_word(cmd_word),
    .busy(busy), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr)
  );

  typedef struct packed {
    logic [1:0]  cs;
    logic        r, c, w;
    logic [12:0] a;
  } pin_t;
  localparam pin_t NOP = '{cs: 2'b11, r: 1'b1, c: 1'b1, w: 1'b1, a: 13'd0};

  pin_t  q[$];
  pin_t  m_pin;
  bit    m_busy, m_pend;
  logic [1:0] m_cke, m_sr, m_act;
  int    m_tcnt;
  int    n_cmp = 0, n_bad = 0, cycles = 0;
  string cur_req = "R1";
  int    ref0_seen = 0, pall_seen = 0;

  task automatic push_seq(pin_t p, int waitn, int reps);
    for (int r = 0; r <= reps; r++) begin
      q.push_back(p);
      for (int k = 0; k < waitn; k++) q.push_back(NOP);
    end
  endtask

  // behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete(); m_pin = NOP; m_busy = 0; m_pend = 0;
      m_cke = 0; m_sr = 0; m_act = 0; m_tcnt = 0;
    end else begin
      bit take, run;
      logic [1:0] s;
      take = !m_busy && !cmd_we && m_pend;
      run  = ctl_en && (m_act != 0);
      if (!run) begin m_tcnt = rfsh_period; m_pend = 0; end
      else if (m_tcnt == 0) begin m_tcnt = rfsh_period; m_pend = 1; end
      else begin m_tcnt--; if (take) m_pend = 0; end
      if (m_busy) begin
        if (q.size() > 0) m_pin = q.pop_front();
        else begin m_busy = 0; m_pin = NOP; end
      end else if (cmd_we) begin
        s = {cmd_word[3], cmd_word[4]};
        case (cmd_word[2:0])
          3'd0: begin
            push_seq(NOP, ((s & m_sr) != 0) ? TXSR + 1 : 0, 0);
            m_cke |= s; m_act |= s; m_sr &= ~s;
          end
          3'd1: begin push_seq(NOP, 0, 0); m_cke |= s; end
          3'd2: push_seq('{~s, 1'b0, 1'b1, 1'b0, 13'h400}, TRP + 1, 0);
          3'd3: push_seq('{~s, 1'b0, 1'b0, 1'b1, 13'd0}, TRC + 1, int'(cmd_word[8:5]));
          3'd4: push_seq('{~s, 1'b0, 1'b0, 1'b0, cmd_word[21:9]}, TMRD + 1, 0);
          3'd5: begin
            push_seq('{~s, 1'b0, 1'b0, 1'b1, 13'd0}, 0, 0);
            m_cke &= ~s; m_sr |= s; m_act &= ~s;
          end
          3'd6: begin push_seq(NOP, 0, 0); m_cke &= ~s; m_act &= ~s; end
          default: push_seq(NOP, 0, 0);
        endcase
        m_pin = q.pop_front(); m_busy = 1;
      end else if (take) begin
        push_seq('{~m_act, 1'b0, 1'b0, 1'b1, 13'd0}, TRC + 1, 0);
        m_pin = q.pop_front(); m_busy = 1;
      end else begin
        m_pin = NOP;
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      n_cmp++;
      if ({busy, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_ba, sd_addr} !==
          {m_busy, m_cke, m_pin.cs, m_pin.r, m_pin.c, m_pin.w, 2'b00, m_pin.a}) begin
        n_bad++;
        $display("FAIL %s cycle %0d: busy=%b cke=%b cs=%b rcw=%b%b%b ba=%b a=%h expected busy=%b cke=%b cs=%b rcw=%b%b%b ba=00 a=%h",
          cur_req, cycles, busy, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_ba, sd_addr,
          m_busy, m_cke, m_pin.cs, m_pin.r, m_pin.c, m_pin.w, m_pin.a);
      end
      if (!sd_cs_n[0] && !sd_ras_n && !sd_cas_n && sd_we_n) ref0_seen++;
      if (!sd_ras_n && sd_cas_n && !sd_we_n && sd_cs_n != 2'b11) pall_seen++;
    end
  end

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_cmd(int code, bit d1, bit d2, int rep, int pay);
    cmd_word = {13'(pay), 4'(rep), d1, d2, 3'(code)};
    cmd_we   = 1'b1;
    @(negedge clk);
    cmd_we   = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected under 150000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    cur_req = "R1";
    chk("R1 busy", int'(busy), 0);
    chk("R1 cke", int'(sd_cke), 0);
    chk("R1 cs_n", int'(sd_cs_n), 3);
    chk("R1 pins", int'({sd_ras_n, sd_cas_n, sd_we_n}), 7);
    chk("R1 addr", int'(sd_addr), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    cur_req = "R6";
    write_cmd(1, 1, 1, 0, 0);
    busy_len(n);
    chk("R6 clock-enable busy", n, 1);
    chk("R6 cke both", int'(sd_cke), 3);

    cur_req = "R2";
    write_cmd(2, 1, 1, 0, 0);
    chk("R2 cs_n", int'(sd_cs_n), 0);
    chk("R2 addr A10", int'(sd_addr), 'h400);
    chk("R2 pins", int'({sd_ras_n, sd_cas_n, sd_we_n}), 3'b010);
    busy_len(n);
    chk("R2 busy cycles", n, TRP + 2);

    cur_req = "R3";
    ref0_seen = 0; pall_seen = 0;
    write_cmd(3, 1, 0, 7, 0);
    chk("R3 cs_n dev0 only", int'(sd_cs_n), 2);
    repeat (5) @(negedge clk);
    cur_req = "R5";
    write_cmd(2, 1, 1, 0, 0);
    cur_req = "R3";
    wait_idle();
    chk("R3 refresh count", ref0_seen, 8);
    chk("R5 ignored precharge", pall_seen, 0);

    cur_req = "R4";
    write_cmd(4, 1, 0, 0, 'h032);
    chk("R4 payload on addr", int'(sd_addr), 'h032);
    chk("R4 pins", int'({sd_ras_n, sd_cas_n, sd_we_n}), 0);
    busy_len(n);
    chk("R4 busy cycles", n, TMRD + 2);

    cur_req = "R10";
    write_cmd(7, 1, 1, 0, 'h1ff);
    chk("R10 pins NOP", int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_addr}), int'({2'b11, 3'b111, 13'd0}));
    chk("R10 cke kept", int'(sd_cke), 3);
    wait_idle();

    cur_req = "R6";
    write_cmd(0, 1, 0, 0, 0);
    busy_len(n);
    chk("R6 normal busy", n, 1);

    cur_req = "R8";
    ctl_en = 1'b1;
    ref0_seen = 0;
    repeat (200) @(negedge clk);
    chk("R8 timed refreshes at least 4", int'(ref0_seen >= 4), 1);

    cur_req = "R9";
    while (!(m_tcnt == 0 && !m_busy)) @(negedge clk);
    @(negedge clk);
    write_cmd(7, 0, 0, 0, 0);
    chk("R9 write first busy", int'(busy), 1);
    chk("R9 write first NOP", int'(sd_ras_n), 1);
    @(negedge clk);
    @(negedge clk);
    chk("R9 deferred refresh", int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), int'({2'b10, 3'b001}));
    wait_idle();

    ctl_en = 1'b0;
    @(negedge clk);
    cur_req = "R7";
    write_cmd(5, 1, 0, 0, 0);
    chk("R7 cke low", int'(sd_cke), 2);
    chk("R7 refresh pins", int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), int'({2'b10, 3'b001}));
    wait_idle();
    write_cmd(0, 1, 0, 0, 0);
    busy_len(n);
    chk("R7 exit busy cycles", n, TXSR + 2);

    cur_req = "R6";
    write_cmd(6, 0, 1, 0, 0);
    chk("R6 power-down cke", int'(sd_cke), 1);
    wait_idle();

    cur_req = "R8";
    ref0_seen = 0;
    repeat (200) @(negedge clk);
    chk("R8 none when disabled", ref0_seen, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule